// File: doc/BRIEF.md
# Asynchronous SCSI Data-Out Engine

This engine moves a stream of data bytes onto a parallel SCSI bus during an asynchronous data-out transfer. Words arrive on a valid/ready stream; each 32-bit word carries two bytes. For every byte the engine adds an odd parity bit, drives the nine data-plus-parity lines in active-low form, and runs a fully interlocked REQ/ACK exchange with the initiator before moving on.

While no transfer is running the engine releases its lines (output enable low, all lines high) so a general-purpose controller can own them. When a word shows up, it first enables the drivers with every line held high for a fixed preparation interval, then presents data. After the last queued byte has been acknowledged and ACK is seen released, it pulses `done_o` and hands the bus back. An even byte count is assumed, so words are never split.

Top module: `scsi_async_tx`

## Requirements
- R1: After reset, and whenever the engine is idle, `oe_o` is 0, `bus_o` is 9'h1FF, `req_n_o` is 1, `busy_o` is 0, `done_o` is 0 and `in_ready` is 0; an idle engine with no valid word stays idle.
- R2: When `in_valid` is seen while idle, `oe_o` rises and for PREP_CYCLES cycles the engine drives `bus_o` = 9'h1FF and `req_n_o` = 1 before any data appears.
- R3: Each word yields two bytes in order: bits [7:0] first, then bits [23:16]; bits [15:8] and [31:24] have no effect on the bus.
- R4: `bus_o[7:0]` carries the byte inverted and `bus_o[8]` the inverted parity bit (a logical 1 is driven low); the parity bit is 1 exactly when the byte has an even number of ones, so the nine logical bits always hold an odd count of ones.
- R5: A byte's value is on `bus_o` for SETUP_CYCLES cycles before `req_n_o` falls and stays unchanged until the initiator releases ACK.
- R6: `req_n_o` stays low until `ack_n_i` is sampled low, returns high one cycle later, and the next byte is not presented until `ack_n_i` is sampled high.
- R7: `in_ready` is high only in the cycle a word is taken: at the end of preparation or at the ACK release of a word's second byte; exactly one handshake occurs per word sent.
- R8: If no word is valid when the ACK release of a word's second byte is sampled, `done_o` pulses for one cycle in the next cycle, together with `busy_o` low and the lines released.
- R9: If a word is valid in the cycle that ACK release is sampled, it is taken at once; no `done_o` pulse occurs, the drivers stay enabled and its first byte follows after SETUP_CYCLES cycles.
- R10: Synchronous reset during a handshake returns the engine to the idle state of R1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Word carrying two bytes |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_ready | output | 1 | Engine takes the word this cycle |
| ack_n_i | input | 1 | Bus ACK line, low = asserted |
| bus_o | output | 9 | Data lines [7:0] and parity [8], active low |
| req_n_o | output | 1 | Bus REQ line, low = asserted |
| oe_o | output | 1 | Enable for the data, parity and REQ drivers |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse when the write has completed |

## Verification
The ACK release of a word's second byte is the single cycle in which the engine either takes the next word or ends the write, so both decisions can fall together. The bench provokes it by raising `in_valid` with a new word at the very clock half in which it releases ACK, and separately by withholding the word until a cycle later. It judges the first case by the absence of `done_o`, enabled drivers and a data setup of exactly SETUP_CYCLES, and the second by a one-cycle `done_o`, released lines and a fresh preparation interval before the late word appears.

// File: rtl/scsi_async_tx.sv
module scsi_async_tx #(
  parameter int PREP_CYCLES  = 2,
  parameter int SETUP_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        ack_n_i,
  output logic [8:0]  bus_o,
  output logic        req_n_o,
  output logic        oe_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int MAXC = (PREP_CYCLES > SETUP_CYCLES) ? PREP_CYCLES : SETUP_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PREP_LD  = CW'(PREP_CYCLES - 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_SETUP, S_REQ, S_REL} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [31:0]  word;
  logic         half;

  wire [7:0] cur     = half ? word[23:16] : word[7:0];
  wire       par     = ~^cur;
  wire       driving = (st == S_SETUP) || (st == S_REQ) || (st == S_REL);

  assign in_ready = ((st == S_PREP) && (cnt == '0)) || ((st == S_REL) && ack_n_i && half);
  assign bus_o    = driving ? ~{par, cur} : 9'h1FF;
  assign req_n_o  = (st != S_REQ);
  assign oe_o     = (st != S_IDLE);
  assign busy_o   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      word   <= '0;
      half   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE:
          if (in_valid) begin
            st  <= S_PREP;
            cnt <= PREP_LD;
          end
        S_PREP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (in_valid) begin
            word <= in_data;
            half <= 1'b0;
            cnt  <= SETUP_LD;
            st   <= S_SETUP;
          end
        S_SETUP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= S_REQ;
        S_REQ:
          if (!ack_n_i) st <= S_REL;
        S_REL:
          if (ack_n_i) begin
            if (!half) begin
              half <= 1'b1;
              cnt  <= SETUP_LD;
              st   <= S_SETUP;
            end else if (in_valid) begin
              word <= in_data;
              half <= 1'b0;
              cnt  <= SETUP_LD;
              st   <= S_SETUP;
            end else begin
              st     <= S_IDLE;
              done_o <= 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!oe_o && bus_o == 9'h1FF && req_n_o));

  a_r4_odd_parity: assert property (@(posedge clk) disable iff (rst)
    !req_n_o |-> ((^(~bus_o)) == 1'b1));

  a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
    (!req_n_o && $past(!req_n_o)) |-> $stable(bus_o));

  a_r6_req_waits_ack: assert property (@(posedge clk) disable iff (rst)
    (!req_n_o && ack_n_i) |=> !req_n_o);

  a_r7_ready_when_busy: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy_o);

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(ack_n_i)));
endmodule

// File: tb/tb_scsi_async_tx.sv
`timescale 1ns/1ps
module tb_scsi_async_tx;
  localparam int PREP  = 2;
  localparam int SETUP = 3;
  localparam int NV    = 8;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'hC3_00_5A_FF, 32'h11_80_22_01, 32'h00_55_FF_AA, 32'hA5_7E_3C_03,
    32'h00_FF_00_00, 32'hFF_01_FF_80, 32'h5A_AA_A5_55, 32'h33_0F_CC_F0
  };

  logic        clk = 0, rst = 1;
  logic [31:0] in_data = '0;
  logic        in_valid = 0, ack_n = 1;
  logic        in_ready, req_n_o, oe_o, busy_o, done_o;
  logic [8:0]  bus_o;
  int checks = 0, errors = 0, fires = 0;

  scsi_async_tx #(.PREP_CYCLES(PREP), .SETUP_CYCLES(SETUP)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .ack_n_i(ack_n), .bus_o(bus_o), .req_n_o(req_n_o), .oe_o(oe_o),
    .busy_o(busy_o), .done_o(done_o));

  always #10 clk = ~clk;

  always @(posedge clk) if (!rst && in_valid && in_ready) fires++;

  function automatic logic [8:0] enc(input logic [7:0] b);
    int ones = 0;
    for (int j = 0; j < 8; j++) ones += b[j];
    return ~{(ones % 2 == 0), b};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_idle(input string r);
    chk(!oe_o && bus_o == 9'h1FF && req_n_o && !busy_o && !done_o && !in_ready, r,
        {oe_o, busy_o, done_o, in_ready, req_n_o, bus_o}, {5'b00001, 9'h1FF});
  endtask

  // Serve one byte as the initiator; leaves ACK asserted, caller releases it.
  task automatic handshake(input logic [7:0] b, input int dly, input int exp_wait, input string r);
    int n = 0;
    do begin @(negedge clk); n++; end while (req_n_o && n < 1000);
    chk(!req_n_o, "R6 req asserted", {31'd0, req_n_o}, 0);
    chk(n == exp_wait, "R5 setup cycles", n, exp_wait);
    chk(bus_o == enc(b), r, bus_o, enc(b));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(!req_n_o && bus_o == enc(b), "R6 req held until ack", {req_n_o, bus_o}, {1'b0, enc(b)});
    end
    ack_n = 0;
    @(negedge clk);
    chk(req_n_o && bus_o == enc(b), "R6 req released after ack", {req_n_o, bus_o}, {1'b1, enc(b)});
    @(negedge clk);
    chk(req_n_o && bus_o == enc(b) && !in_ready, "R5 data held until ack release",
        {in_ready, req_n_o, bus_o}, {2'b01, enc(b)});
  endtask

  task automatic check_prep();
    for (int k = 0; k < PREP; k++) begin
      @(negedge clk);
      chk(oe_o && bus_o == 9'h1FF && req_n_o, "R2 lines high before data",
          {oe_o, req_n_o, bus_o}, {2'b11, 9'h1FF});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst = 0;
    repeat (5) @(negedge clk);
    check_idle("R1 idle without valid");

    // Stream of table words, next word offered exactly at ACK release (R9)
    in_data = VEC[0]; in_valid = 1;
    check_prep();
    for (int i = 0; i < NV; i++) begin
      handshake(VEC[i][7:0], i % 3, SETUP + 1, "R3 R4 low byte");
      ack_n = 1;
      handshake(VEC[i][23:16], (i + 1) % 3, SETUP + 1, "R3 R4 upper byte");
      ack_n = 1;
      if (i < NV - 1) begin
        in_data = VEC[i + 1];
        @(negedge clk);
        chk(!done_o && oe_o && busy_o, "R9 continue without done", {done_o, oe_o, busy_o}, 3'b011);
        handshake(VEC[i + 1][7:0], 0, SETUP, "R9 next word first byte");
        ack_n = 1;
        handshake(VEC[i + 1][23:16], 1, SETUP + 1, "R3 next word upper byte");
        ack_n = 1;
        i++;
        if (i < NV - 1) begin
          in_data = VEC[i + 1];
          @(negedge clk);
          chk(!done_o && busy_o, "R9 continue without done", {done_o, busy_o}, 2'b01);
          handshake(VEC[i + 1][7:0], 2, SETUP, "R3 R4 low byte");
          ack_n = 1;
          handshake(VEC[i + 1][23:16], 0, SETUP + 1, "R3 R4 upper byte");
          ack_n = 1;
          i++;
          if (i < NV - 1) in_data = VEC[i + 1];
          else in_valid = 0;
          if (i < NV - 1) begin
            @(negedge clk);
            chk(!done_o, "R9 no done", {31'd0, done_o}, 0);
            handshake(VEC[i + 1][7:0], 0, SETUP, "R3 low byte");
            ack_n = 1;
            handshake(VEC[i + 1][23:16], 0, SETUP + 1, "R3 upper byte");
            ack_n = 1;
            i++;
            if (i < NV - 1) in_data = VEC[i + 1];
            else in_valid = 0;
            if (i < NV - 1) begin
              @(negedge clk);
              handshake(VEC[i + 1][7:0], 1, SETUP, "R3 low byte");
              ack_n = 1;
              handshake(VEC[i + 1][23:16], 1, SETUP + 1, "R3 upper byte");
              ack_n = 1;
              i++;
              if (i < NV - 1) in_data = VEC[i + 1];
              else in_valid = 0;
            end
          end
        end
      end else in_valid = 0;
    end
    @(negedge clk);
    chk(done_o && !busy_o && !oe_o && bus_o == 9'h1FF && req_n_o, "R8 done and release",
        {done_o, busy_o, oe_o, req_n_o, bus_o}, {4'b1001, 9'h1FF});
    @(negedge clk);
    check_idle("R8 done single pulse");
    chk(fires == NV, "R7 one take per word", fires, NV);

    // Late word: done first, then a fresh preparation interval
    fires = 0;
    in_data = 32'hEE_96_EE_69; in_valid = 1;
    check_prep();
    handshake(8'h69, 0, SETUP + 1, "R4 byte 69");
    ack_n = 1;
    handshake(8'h96, 0, SETUP + 1, "R3 ignores bits 15:8 and 31:24");
    ack_n = 1; in_valid = 0;
    @(negedge clk);
    chk(done_o && !oe_o, "R8 done when no word", {done_o, oe_o}, 2'b10);
    in_data = 32'h00_7F_00_00; in_valid = 1;
    check_prep();
    handshake(8'h00, 0, SETUP + 1, "R4 byte 00");
    ack_n = 1;
    handshake(8'h7F, 0, SETUP + 1, "R4 byte 7F");
    ack_n = 1; in_valid = 0;
    @(negedge clk);
    chk(done_o, "R8 done", {31'd0, done_o}, 1);
    chk(fires == 2, "R7 takes for late words", fires, 2);

    // Reset while REQ is asserted
    in_data = 32'h00_01_00_02; in_valid = 1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (req_n_o && n < 1000);
    end
    chk(!req_n_o, "R10 req low before reset", {31'd0, req_n_o}, 0);
    rst = 1; in_valid = 0;
    @(negedge clk);
    check_idle("R10 reset mid-handshake");
    rst = 0;
    repeat (3) @(negedge clk);
    check_idle("R1 idle after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule